// File: doc/BRIEF.md
# TMDS Clock-Lane Word Pattern Generator

This block produces the stream of 10-bit characters that drives the clock lane of a TMDS link, one character per clock of the character-rate domain. The lane does not carry data. It carries a programmable repeating cycle of four 10-bit words, and a serializer downstream turns that cycle into the link clock. Two settings are typical. At normal rates every word is five ones followed by five zeros, which gives a clock at one tenth of the bit rate. At rates above 340 MHz pixel clock the words are two all-zero words followed by two all-one words, which gives a clock at one fortieth of the bit rate.

Software programs the four words through two pattern registers, each of which holds two words. It then issues a load command, which copies the programmed words into the active set. A run command starts the continuous output of the active set. Because the active set is separate from the pattern registers, the registers can be rewritten while the lane runs without disturbing it. The serializer and the analog driver are outside this block.

Top module: `tmds_clk_pattern_gen`

## Requirements
- R1: After reset `clk_word` is 0, and it stays 0 until the first run command, even when patterns are written and loaded before that command.
- R2: A write to address 0 sets word 0 from data bits [9:0] and word 1 from bits [25:16]. A write to address 1 sets word 2 from bits [9:0] and word 3 from bits [25:16]. All other data bits of these writes are ignored.
- R3: Writing the value 1 to the control address (address 2) copies the four programmed words into the active set at that clock edge. A load issued while the lane runs takes effect from the next character and does not disturb the word order.
- R4: Writing the value 2 to the control address starts output, and word 0 appears in the cycle after that write. A run command issued while already running restarts the cycle at word 0.
- R5: While running, the output advances one word per clock in the order 0, 1, 2, 3 and then repeats, with no end.
- R6: Pattern-register writes made after a load do not change the output until the next load command.
- R7: A run command with no prior load outputs the reset-value words, which are all zeros.
- R8: Writes to the control address with any value other than 1 or 2 have no effect on the output, and a write to address 3 has no effect either.
- R9: With both pattern registers at 0x001F001F every output word is 0x01F. With address 0 at 0 and address 1 at 0x03FF03FF the output cycle is 0x000, 0x000, 0x3FF, 0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Write address: 0 and 1 are pattern registers, 2 is control |
| cfg_wdata | input | 32 | Write data |
| clk_word | output | 10 | Clock-lane character, one per clock |

## Verification
The hardest case to reach is the interaction between a reload or a restart and a cycle that is already in progress. That means a load landing in the middle of the word cycle, and pattern writes landing while an older set is still being sent. The bench reaches this by issuing its configuration writes one per clock while the lane runs, so every command falls at a known phase. It keeps a per-edge model of the programmed set, the active set and the phase. It then compares each character against this model, and it also compares against the literal 1:10 and 1:40 words.

// File: rtl/tmds_ckpat_pkg.sv
package tmds_ckpat_pkg;
    localparam int unsigned CKP_WORD_W    = 10;
    localparam int unsigned CKP_HALF_W    = 16;
    localparam int unsigned CKP_DATA_W    = 32;
    localparam int unsigned CKP_NUM_WORDS = 4;
    localparam int unsigned CKP_ADDR_W    = 2;

    localparam int unsigned CKP_CODE_LOAD = 1;
    localparam int unsigned CKP_CODE_RUN  = 2;

    typedef enum logic [1:0] {
        CKP_CMD_NONE = 2'd0,
        CKP_CMD_LOAD = 2'd1,
        CKP_CMD_RUN  = 2'd2
    } ckp_cmd_e;
endpackage

// File: rtl/ckp_regs.sv
module ckp_regs
    import tmds_ckpat_pkg::*;
#(
    parameter int unsigned WORD_W    = CKP_WORD_W,
    parameter int unsigned HALF_W    = CKP_HALF_W,
    parameter int unsigned DATA_W    = CKP_DATA_W,
    parameter int unsigned NUM_WORDS = CKP_NUM_WORDS,
    parameter int unsigned ADDR_W    = CKP_ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_WORDS*WORD_W-1:0]   prog_words,
    output ckp_cmd_e                      cmd
);
    localparam int unsigned WPR      = DATA_W / HALF_W;
    localparam int unsigned NUM_REGS = (NUM_WORDS + WPR - 1) / WPR;
    localparam int unsigned CTL_ADDR = NUM_REGS;

    typedef struct packed {
        logic [NUM_WORDS*WORD_W-1:0] words;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NUM_WORDS-1:0]        hit;
    logic [NUM_WORDS*WORD_W-1:0] field;
    logic                        ctl_hit;

    genvar g;
    generate
        for (g = 0; g < NUM_WORDS; g++) begin : g_word
            assign hit[g] = wr_en && (wr_addr == ADDR_W'(g / WPR));
            assign field[g*WORD_W +: WORD_W] = wr_data[(g % WPR)*HALF_W +: WORD_W];

            AST_FIELD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                hit[g] |=> prog_words[g*WORD_W +: WORD_W] ==
                           $past(wr_data[(g % WPR)*HALF_W +: WORD_W])); // R2
        end
    endgenerate

    assign ctl_hit = wr_en && (wr_addr == ADDR_W'(CTL_ADDR));

    always_comb begin
        regs_d = regs_q;
        cmd    = CKP_CMD_NONE;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (hit[k]) regs_d.words[k*WORD_W +: WORD_W] = field[k*WORD_W +: WORD_W];
        end
        if (ctl_hit) begin
            if (wr_data == DATA_W'(CKP_CODE_LOAD))     cmd = CKP_CMD_LOAD;
            else if (wr_data == DATA_W'(CKP_CODE_RUN)) cmd = CKP_CMD_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign prog_words = regs_q.words;

    AST_PAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(prog_words)); // R6
endmodule

// File: rtl/ckp_seq.sv
module ckp_seq
    import tmds_ckpat_pkg::*;
#(
    parameter int unsigned WORD_W    = CKP_WORD_W,
    parameter int unsigned NUM_WORDS = CKP_NUM_WORDS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  ckp_cmd_e                    cmd,
    input  logic [NUM_WORDS*WORD_W-1:0] prog_words,
    output logic [WORD_W-1:0]           word_out
);
    localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        logic [NUM_WORDS*WORD_W-1:0] act;
        logic                        run;
        logic [IDX_W-1:0]            idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.run) begin
            seq_d.idx = (seq_q.idx == LAST_IDX) ? '0 : seq_q.idx + 1'b1;
        end
        if (cmd == CKP_CMD_LOAD) seq_d.act = prog_words;
        if (cmd == CKP_CMD_RUN) begin
            seq_d.run = 1'b1;
            seq_d.idx = '0;
        end
        word_out = seq_q.run ? seq_q.act[seq_q.idx*WORD_W +: WORD_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    AST_RUN_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CKP_CMD_RUN) |=> (seq_q.run && seq_q.idx == '0)); // R4
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && cmd != CKP_CMD_RUN) |=>
            seq_q.idx == (($past(seq_q.idx) == LAST_IDX) ? '0 : $past(seq_q.idx) + 1'b1)); // R5
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.run |=> seq_q.run); // R5
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CKP_CMD_LOAD) |=> seq_q.act == $past(prog_words)); // R3
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CKP_CMD_LOAD) |=> $stable(seq_q.act)); // R6
endmodule

// File: rtl/tmds_clk_pattern_gen.sv
module tmds_clk_pattern_gen
    import tmds_ckpat_pkg::*;
#(
    parameter int unsigned WORD_W    = CKP_WORD_W,
    parameter int unsigned HALF_W    = CKP_HALF_W,
    parameter int unsigned DATA_W    = CKP_DATA_W,
    parameter int unsigned NUM_WORDS = CKP_NUM_WORDS,
    parameter int unsigned ADDR_W    = CKP_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] clk_word
);
    ckp_cmd_e                    cmd;
    logic [NUM_WORDS*WORD_W-1:0] prog_words;

    ckp_regs #(
        .WORD_W(WORD_W), .HALF_W(HALF_W), .DATA_W(DATA_W),
        .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
        .wr_data(cfg_wdata), .prog_words(prog_words), .cmd(cmd)
    );

    ckp_seq #(
        .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .prog_words(prog_words),
        .word_out(clk_word)
    );
endmodule

// File: tb/sim_tmds_clk_pattern_gen.sv
module sim_tmds_clk_pattern_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [9:0]  clk_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [9:0] m_prog [4];
    logic [9:0] m_act  [4];
    bit         m_run;
    int         m_ph;

    always #10 clk = ~clk;

    tmds_clk_pattern_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .clk_word(clk_word)
    );

    task automatic chk_lit(input logic [9:0] exp, input string tag);
        n_chk++;
        if (clk_word !== exp) begin
            n_fail++;
            $display("FAIL %s: clk_word=%h expected=%h", tag, clk_word, exp);
        end
    endtask

    task automatic do_reset();
        cfg_we = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        for (int i = 0; i < 4; i++) begin m_prog[i] = '0; m_act[i] = '0; end
        m_run = 1'b0;
        m_ph  = 0;
    endtask

    task automatic tick(input logic we, input logic [1:0] a, input logic [31:0] dt, input string tag);
        cfg_we = we; cfg_addr = a; cfg_wdata = dt;
        @(negedge clk);
        cfg_we = 1'b0;
        if (m_run) m_ph = (m_ph + 1) % 4;
        if (we) begin
            case (a)
                2'd0: begin m_prog[0] = dt[9:0]; m_prog[1] = dt[25:16]; end
                2'd1: begin m_prog[2] = dt[9:0]; m_prog[3] = dt[25:16]; end
                2'd2: begin
                    if (dt == 32'd1) m_act = m_prog;
                    else if (dt == 32'd2) begin m_run = 1'b1; m_ph = 0; end
                end
                default: ;
            endcase
        end
        chk_lit(m_run ? m_act[m_ph] : 10'h000, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1'b0, 2'd0, 32'd0, tag);
    endtask

    task automatic t_reset();
        do_reset();
        chk_lit(10'h000, "R1 reset");
        idle(3, "R1 idle");
        tick(1'b1, 2'd0, 32'h0155_02AA, "R1 wr");
        tick(1'b1, 2'd1, 32'h0333_00CC, "R1 wr");
        tick(1'b1, 2'd2, 32'd1, "R1 load");
        idle(4, "R1 loaded no run");
    endtask

    task automatic t_empty_run();
        do_reset();
        tick(1'b1, 2'd2, 32'd2, "R7 run");
        idle(6, "R7 zeros");
    endtask

    task automatic t_normal();
        do_reset();
        tick(1'b1, 2'd0, 32'h001F_001F, "R9 wr");
        tick(1'b1, 2'd1, 32'h001F_001F, "R9 wr");
        tick(1'b1, 2'd2, 32'd1, "R3 load");
        tick(1'b1, 2'd2, 32'd2, "R4 run");
        chk_lit(10'h01F, "R9 div10");
        for (int i = 0; i < 8; i++) begin
            tick(1'b0, 2'd0, 32'd0, "R5 div10");
            chk_lit(10'h01F, "R9 div10");
        end
    endtask

    task automatic t_high();
        tick(1'b1, 2'd0, 32'h0000_0000, "R9 wr");
        tick(1'b1, 2'd1, 32'h03FF_03FF, "R9 wr");
        tick(1'b1, 2'd2, 32'd1, "R3 load mid-run");
        idle(3, "R3 after load");
        tick(1'b1, 2'd2, 32'd2, "R4 run");
        chk_lit(10'h000, "R9 div40 w0");
        tick(1'b0, 2'd0, 32'd0, "R5"); chk_lit(10'h000, "R9 div40 w1");
        tick(1'b0, 2'd0, 32'd0, "R5"); chk_lit(10'h3FF, "R9 div40 w2");
        tick(1'b0, 2'd0, 32'd0, "R5"); chk_lit(10'h3FF, "R9 div40 w3");
        tick(1'b0, 2'd0, 32'd0, "R5"); chk_lit(10'h000, "R9 div40 wrap");
    endtask

    task automatic t_order();
        tick(1'b1, 2'd0, 32'hFC2A_FD55, "R2 wr junk");
        tick(1'b1, 2'd1, 32'h7DC3_A60F, "R2 wr junk");
        tick(1'b1, 2'd2, 32'd1, "R3 load");
        idle(9, "R5 order R2 fields");
    endtask

    task automatic t_shadow();
        tick(1'b1, 2'd0, 32'h0111_0222, "R6 wr");
        tick(1'b1, 2'd1, 32'h0333_0044, "R6 wr");
        idle(5, "R6 old words");
        tick(1'b1, 2'd2, 32'd1, "R6 reload");
        idle(5, "R6 new words");
    endtask

    task automatic t_restart();
        idle(2, "R4 pre");
        tick(1'b1, 2'd2, 32'd2, "R4 restart");
        chk_lit(10'h222, "R4 restart word0");
        idle(3, "R4 post");
    endtask

    task automatic t_bad_ctl();
        tick(1'b1, 2'd0, 32'h0AAA_0155, "R8 wr");
        tick(1'b1, 2'd2, 32'd3, "R8 ctl3");
        tick(1'b1, 2'd2, 32'd0, "R8 ctl0");
        tick(1'b1, 2'd2, 32'h0000_0101, "R8 ctl257");
        tick(1'b1, 2'd3, 32'd1, "R8 addr3");
        tick(1'b1, 2'd3, 32'd2, "R8 addr3");
        idle(5, "R8 unchanged");
    endtask

    initial begin
        t_reset();
        t_empty_run();
        t_normal();
        t_high();
        t_order();
        t_shadow();
        t_restart();
        t_bad_ctl();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule